// File: doc/BRIEF.md
# Vector Register Dependency Scoreboard

This block tracks hazards for the physical vector registers of one SIMD lane group. It keeps two flags for each register. The pending flag is set when an instruction that writes the register issues. The busy flag is set when that instruction starts to execute, and it stays set until the result can be read. Before an instruction is allowed to go ahead, its operand list is presented to the block. A single combinational output then says whether every operand is free of both flags.

Operands wider than four bytes cover two adjacent registers, and the register after the last one is register zero. An arithmetic destination releases itself: it loads a per-register countdown at execute and leaves the busy state when the countdown ends. The countdown length depends on the operand width. Memory loads, atomics and fences stay busy until a release request arrives on the release port. That request names a set of registers and an optional delay. Refused checks are counted in one of two counters, chosen by the kind of operand that caused the refusal.

Top module: `vreg_scoreboard`

## Requirements
- R1: After reset every pending flag, busy flag and countdown is clear, `chk_ready` is 1 for any operand list, and both stall counters read 0.
- R2: `iss_valid` sets the pending flag of the register `iss_idx` (and of the register after it when `iss_wide` is 1). A valid operand on a pending register makes `chk_ready` 0.
- R3: `ex_valid` sets the busy flag and clears the pending flag of its register(s) in the same edge. When `ex_hold` is 0, the busy flag is visible for exactly SP_LAT cycles after the execute edge for a narrow operand (`ex_wide`=0) and DP_LAT cycles for a wide operand.
- R4: A wide operand at index i also covers index (i+1) modulo NUM_REGS, so index NUM_REGS-1 pairs with index 0. This applies to checks, issue, execute and release. On a check the flags of the two registers are ORed.
- R5: `chk_ready` is 1 only when no operand slot with its valid bit set touches a register whose busy or pending flag is set. Slots with the valid bit at 0 have no effect.
- R6: On an edge with `chk_valid`=1 and `chk_ready`=0, exactly one counter increments. The lowest-numbered blocked slot decides which: `stall_wax` if that slot is a destination (`chk_op_dst`=1), otherwise `stall_raw`. Both counters are unchanged whenever `chk_valid`=0 or `chk_ready`=1.
- R7: An execute with `ex_hold`=1 leaves its register(s) busy with no countdown, for as long as no release names them.
- R8: A release (`rel_valid`) applies to every register whose bit is set in `rel_mask`. With `rel_delay`=0 the busy flag clears on the release edge. With `rel_delay`=d>0 it stays visible for d cycles after that edge.
- R9: If a set and a clear of the same flag meet in one edge, the set wins. An issue and an execute on the same register leave it both pending and busy. An execute on a register whose countdown is ending, or that is being released, keeps it busy and restarts the countdown.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chk_valid | input | 1 | The operand list is a real check (counts stalls) |
| chk_op_vld | input | NUM_OPS | Per-slot operand present |
| chk_op_idx | input | NUM_OPS*IDX_W | Per-slot register index, slot k at bits [k*IDX_W +: IDX_W] |
| chk_op_wide | input | NUM_OPS | Per-slot operand wider than four bytes |
| chk_op_dst | input | NUM_OPS | Per-slot operand is a destination |
| chk_ready | output | 1 | No valid operand is blocked |
| iss_valid | input | 1 | Issue mark request |
| iss_idx | input | IDX_W | Issued destination register |
| iss_wide | input | 1 | Issued destination is wide |
| ex_valid | input | 1 | Execute request |
| ex_idx | input | IDX_W | Executing destination register |
| ex_wide | input | 1 | Executing destination is wide |
| ex_hold | input | 1 | Load, atomic or fence: no timed release |
| rel_valid | input | 1 | External release request |
| rel_mask | input | NUM_REGS | Registers to release, bit r for register r |
| rel_delay | input | LAT_W | Cycles before the release takes effect |
| stall_wax | output | CNT_W | Stalls caused by a destination operand |
| stall_raw | output | CNT_W | Stalls caused by a source operand |

## Verification
Isolated narrow probes of a single register show whether the pending and busy flags are set and cleared on the right edges. They also show whether the countdown ends on the exact cycle. Wide probes and wide marks at the last index show whether the pairing wraps to register zero rather than stopping. Operand lists that mix ready slots, disabled slots on blocked registers, and blocked slots of both kinds in different orders tell apart the readiness and stall-attribution rules. A long random stretch with overlapping issue, execute and release traffic exposes the collision priorities.

// File: rtl/vreg_scoreboard.sv
module vreg_scoreboard #(
  parameter int NUM_REGS  = 16,
  parameter int MIN_ALLOC = 4,
  parameter int NUM_OPS   = 4,
  parameter int LAT_W     = 4,
  parameter int SP_LAT    = 4,
  parameter int DP_LAT    = 7,
  parameter int CNT_W     = 16,
  localparam int IDX_W    = $clog2(NUM_REGS)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     chk_valid,
  input  logic [NUM_OPS-1:0]       chk_op_vld,
  input  logic [NUM_OPS*IDX_W-1:0] chk_op_idx,
  input  logic [NUM_OPS-1:0]       chk_op_wide,
  input  logic [NUM_OPS-1:0]       chk_op_dst,
  output logic                     chk_ready,
  input  logic                     iss_valid,
  input  logic [IDX_W-1:0]         iss_idx,
  input  logic                     iss_wide,
  input  logic                     ex_valid,
  input  logic [IDX_W-1:0]         ex_idx,
  input  logic                     ex_wide,
  input  logic                     ex_hold,
  input  logic                     rel_valid,
  input  logic [NUM_REGS-1:0]      rel_mask,
  input  logic [LAT_W-1:0]         rel_delay,
  output logic [CNT_W-1:0]         stall_wax,
  output logic [CNT_W-1:0]         stall_raw
);

  if (NUM_REGS % 2 != 0) begin : g_odd_regs
    $error("NUM_REGS must be even");
  end
  if (NUM_REGS % MIN_ALLOC != 0) begin : g_bad_granule
    $error("NUM_REGS must be a multiple of MIN_ALLOC");
  end
  if (SP_LAT < 1 || DP_LAT < 1 || SP_LAT >= 2**LAT_W || DP_LAT >= 2**LAT_W) begin : g_bad_lat
    $error("latencies must fit LAT_W and be nonzero");
  end

  function automatic logic [NUM_REGS-1:0] span(input logic [IDX_W-1:0] idx, input logic wide);
    logic [NUM_REGS-1:0] m;
    logic [IDX_W-1:0]    nxt;
    m      = '0;
    nxt    = (idx == IDX_W'(NUM_REGS - 1)) ? '0 : idx + 1'b1;
    m[idx] = 1'b1;
    if (wide) m[nxt] = 1'b1;
    return m;
  endfunction

  logic [NUM_REGS-1:0]       busy_q, infl_q;
  logic [NUM_REGS*LAT_W-1:0] cnt_q;

  wire [NUM_REGS-1:0] iss_m   = iss_valid ? span(iss_idx, iss_wide) : '0;
  wire [NUM_REGS-1:0] ex_m    = ex_valid  ? span(ex_idx, ex_wide)   : '0;
  wire [NUM_REGS-1:0] rel_m   = rel_valid ? rel_mask                : '0;
  wire [NUM_REGS-1:0] flagged = busy_q | infl_q;
  wire [LAT_W-1:0]    ex_lat  = ex_hold ? '0 : (ex_wide ? LAT_W'(DP_LAT) : LAT_W'(SP_LAT));

  for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
    wire [LAT_W-1:0] cnt     = cnt_q[r*LAT_W +: LAT_W];
    wire             expire  = (cnt == LAT_W'(1));
    wire             rel_now = rel_m[r] && (rel_delay == '0);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        busy_q[r]               <= 1'b0;
        infl_q[r]               <= 1'b0;
        cnt_q[r*LAT_W +: LAT_W] <= '0;
      end else begin
        if (ex_m[r])                busy_q[r] <= 1'b1;
        else if (expire || rel_now) busy_q[r] <= 1'b0;

        if (iss_m[r])     infl_q[r] <= 1'b1;
        else if (ex_m[r]) infl_q[r] <= 1'b0;

        if (ex_m[r])          cnt_q[r*LAT_W +: LAT_W] <= ex_lat;
        else if (rel_m[r])    cnt_q[r*LAT_W +: LAT_W] <= rel_delay;
        else if (cnt != '0)   cnt_q[r*LAT_W +: LAT_W] <= cnt - 1'b1;
      end
    end
  end

  logic [NUM_OPS-1:0] blk;
  for (genvar k = 0; k < NUM_OPS; k++) begin : g_op
    assign blk[k] = chk_op_vld[k] &&
                    |(flagged & span(chk_op_idx[k*IDX_W +: IDX_W], chk_op_wide[k]));
  end

  assign chk_ready = ~|blk;

  logic first_dst;
  always_comb begin
    first_dst = 1'b0;
    for (int k = NUM_OPS - 1; k >= 0; k--)
      if (blk[k]) first_dst = chk_op_dst[k];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stall_wax <= '0;
      stall_raw <= '0;
    end else if (chk_valid && !chk_ready) begin
      if (first_dst) stall_wax <= stall_wax + 1'b1;
      else           stall_raw <= stall_raw + 1'b1;
    end
  end

endmodule

// File: rtl/vreg_scoreboard_chk.sv
module vreg_scoreboard_chk #(
  parameter int NUM_REGS = 16,
  parameter int LAT_W    = 4,
  parameter int CNT_W    = 16,
  parameter int IDX_W    = 4
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      iss_valid,
  input logic [IDX_W-1:0]          iss_idx,
  input logic                      ex_valid,
  input logic [IDX_W-1:0]          ex_idx,
  input logic                      rel_valid,
  input logic                      chk_valid,
  input logic                      chk_ready,
  input logic [CNT_W-1:0]          stall_wax,
  input logic [CNT_W-1:0]          stall_raw,
  input logic [NUM_REGS-1:0]       busy_q,
  input logic [NUM_REGS-1:0]       infl_q,
  input logic [NUM_REGS*LAT_W-1:0] cnt_q
);

  a_r2_issue_marks: assert property (@(posedge clk) disable iff (!rst_n)
    iss_valid |=> infl_q[$past(iss_idx)]);

  a_r3_exec_busy: assert property (@(posedge clk) disable iff (!rst_n)
    ex_valid |=> busy_q[$past(ex_idx)]);

  a_r3_exec_unmarks: assert property (@(posedge clk) disable iff (!rst_n)
    ex_valid && !iss_valid |=> !infl_q[$past(ex_idx)]);

  a_r5_clear_is_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q == '0) && (infl_q == '0) |-> chk_ready);

  a_r6_one_count: assert property (@(posedge clk) disable iff (!rst_n)
    chk_valid && !chk_ready |=> (stall_wax != $past(stall_wax)) != (stall_raw != $past(stall_raw)));

  a_r6_no_count: assert property (@(posedge clk) disable iff (!rst_n)
    !(chk_valid && !chk_ready) |=> $stable(stall_wax) && $stable(stall_raw));

  for (genvar r = 0; r < NUM_REGS; r++) begin : g_hold
    a_r7_hold_stays: assert property (@(posedge clk) disable iff (!rst_n)
      busy_q[r] && (cnt_q[r*LAT_W +: LAT_W] == '0) && !rel_valid |=> busy_q[r]);
  end

endmodule

bind vreg_scoreboard vreg_scoreboard_chk #(
  .NUM_REGS(NUM_REGS), .LAT_W(LAT_W), .CNT_W(CNT_W), .IDX_W(IDX_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .iss_valid(iss_valid), .iss_idx(iss_idx),
  .ex_valid(ex_valid), .ex_idx(ex_idx), .rel_valid(rel_valid),
  .chk_valid(chk_valid), .chk_ready(chk_ready),
  .stall_wax(stall_wax), .stall_raw(stall_raw),
  .busy_q(busy_q), .infl_q(infl_q), .cnt_q(cnt_q)
);

// File: tb/vreg_scoreboard_tb.sv
module vreg_scoreboard_tb;
  localparam int N = 16, OPS = 4, LW = 4, SP = 4, DP = 7, CW = 16, IW = 4;

  logic clk = 0, rst_n = 0;
  logic chk_valid = 0;
  logic [OPS-1:0] chk_op_vld = 0, chk_op_wide = 0, chk_op_dst = 0;
  logic [OPS*IW-1:0] chk_op_idx = 0;
  logic chk_ready;
  logic iss_valid = 0, iss_wide = 0, ex_valid = 0, ex_wide = 0, ex_hold = 0, rel_valid = 0;
  logic [IW-1:0] iss_idx = 0, ex_idx = 0;
  logic [N-1:0] rel_mask = 0;
  logic [LW-1:0] rel_delay = 0;
  logic [CW-1:0] stall_wax, stall_raw;

  vreg_scoreboard #(.NUM_REGS(N), .MIN_ALLOC(4), .NUM_OPS(OPS), .LAT_W(LW),
                    .SP_LAT(SP), .DP_LAT(DP), .CNT_W(CW)) u_dut (
    .clk, .rst_n, .chk_valid, .chk_op_vld, .chk_op_idx, .chk_op_wide, .chk_op_dst,
    .chk_ready, .iss_valid, .iss_idx, .iss_wide, .ex_valid, .ex_idx, .ex_wide,
    .ex_hold, .rel_valid, .rel_mask, .rel_delay, .stall_wax, .stall_raw);

  always #10 clk = ~clk;

  int m_busy[N], m_infl[N], m_cnt[N];
  int m_wax = 0, m_raw = 0;
  int n_cmp = 0, n_bad = 0;
  string tag = "R1 reset";
  bit live = 0;

  function automatic bit covers(int i, bit w, int r);
    return (r == i) || (w && r == (i + 1) % N);
  endfunction

  function automatic int first_blocked();
    for (int k = 0; k < OPS; k++) begin
      if (chk_op_vld[k]) begin
        for (int r = 0; r < N; r++)
          if (covers(int'(chk_op_idx[k*IW +: IW]), chk_op_wide[k], r) && (m_busy[r] || m_infl[r]))
            return k;
      end
    end
    return -1;
  endfunction

  initial for (int r = 0; r < N; r++) begin m_busy[r] = 0; m_infl[r] = 0; m_cnt[r] = 0; end

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int r = 0; r < N; r++) begin m_busy[r] = 0; m_infl[r] = 0; m_cnt[r] = 0; end
      m_wax = 0; m_raw = 0;
    end else begin
      int fb;
      fb = first_blocked();
      if (chk_valid && fb >= 0) begin
        if (chk_op_dst[fb]) m_wax++; else m_raw++;
      end
      for (int r = 0; r < N; r++) begin
        bit ih, eh, rh;
        int c;
        ih = iss_valid && covers(int'(iss_idx), iss_wide, r);
        eh = ex_valid && covers(int'(ex_idx), ex_wide, r);
        rh = rel_valid && rel_mask[r];
        c  = m_cnt[r];
        if (eh) m_busy[r] = 1;
        else if (c == 1 || (rh && rel_delay == 0)) m_busy[r] = 0;
        if (ih) m_infl[r] = 1;
        else if (eh) m_infl[r] = 0;
        if (eh) m_cnt[r] = ex_hold ? 0 : (ex_wide ? DP : SP);
        else if (rh) m_cnt[r] = int'(rel_delay);
        else if (c > 0) m_cnt[r] = c - 1;
      end
    end
    live = 1;
  end

  always @(negedge clk) if (live) begin
    bit exp_rdy;
    exp_rdy = (first_blocked() < 0);
    n_cmp++;
    if (chk_ready !== exp_rdy) begin
      n_bad++;
      $display("FAIL %s: chk_ready=%0d expected %0d at %0t", tag, chk_ready, exp_rdy, $time);
    end
    n_cmp++;
    if (stall_wax !== CW'(m_wax) || stall_raw !== CW'(m_raw)) begin
      n_bad++;
      $display("FAIL %s (R6 counters): wax=%0d raw=%0d expected %0d %0d at %0t",
               tag, stall_wax, stall_raw, m_wax, m_raw, $time);
    end
  end

  task automatic tick();
    @(negedge clk); #2;
    chk_valid = 0; chk_op_vld = 0; chk_op_wide = 0; chk_op_dst = 0; chk_op_idx = 0;
    iss_valid = 0; ex_valid = 0; ex_hold = 0; rel_valid = 0; rel_mask = 0; rel_delay = 0;
  endtask

  task automatic probe(int k, int idx, bit w, bit d);
    chk_valid = 1; chk_op_vld[k] = 1; chk_op_idx[k*IW +: IW] = IW'(idx);
    chk_op_wide[k] = w; chk_op_dst[k] = d;
  endtask

  task automatic watch(int idx, bit w, int cycles);
    for (int i = 0; i < cycles; i++) begin tick(); probe(0, idx, w, 0); end
  endtask

  bit done = 0;
  initial begin
    #(200000 * 20);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1;
    tag = "R1 reset state";
    for (int r = 0; r < N; r++) begin tick(); probe(r % OPS, r, r[0], r[1]); end

    tag = "R2 issue pending";
    tick(); iss_valid = 1; iss_idx = 3;
    watch(3, 0, 3);
    tag = "R3 execute narrow";
    tick(); ex_valid = 1; ex_idx = 3;
    watch(3, 0, SP + 3);
    tag = "R3 execute wide";
    tick(); ex_valid = 1; ex_idx = 6; ex_wide = 1;
    watch(7, 0, DP + 3);

    tag = "R4 wrap pairing";
    tick(); iss_valid = 1; iss_idx = 15; iss_wide = 1;
    watch(0, 0, 2);
    tick(); ex_valid = 1; ex_idx = 15; ex_wide = 1;
    watch(14, 1, DP + 2);

    tag = "R5 disabled slots";
    tick(); ex_valid = 1; ex_idx = 9; ex_hold = 1;
    tick(); probe(0, 1, 0, 0); probe(2, 5, 1, 1); chk_op_idx[1*IW +: IW] = 9;
    tick(); probe(3, 8, 1, 0);

    tag = "R6 stall attribution";
    tick(); probe(0, 2, 0, 0); probe(1, 9, 0, 1); probe(2, 9, 0, 0);
    tick(); probe(1, 8, 1, 0); probe(3, 9, 0, 1);
    tick(); probe(2, 9, 0, 1); chk_valid = 0;

    tag = "R7 hold stays busy";
    watch(9, 0, 12);
    tag = "R8 release now";
    tick(); rel_valid = 1; rel_mask = 16'h0200; probe(0, 9, 0, 0);
    watch(9, 0, 2);
    tick(); ex_valid = 1; ex_idx = 10; ex_hold = 1;
    tick(); rel_valid = 1; rel_mask = 16'h0400; rel_delay = 3;
    tag = "R8 release delayed";
    watch(10, 0, 5);

    tag = "R9 collisions";
    tick(); ex_valid = 1; ex_idx = 4;
    repeat (SP - 1) begin tick(); probe(0, 4, 0, 0); end
    tick(); ex_valid = 1; ex_idx = 4; probe(0, 4, 0, 0);
    watch(4, 0, SP + 2);
    tick(); iss_valid = 1; iss_idx = 12; ex_valid = 1; ex_idx = 12;
    watch(12, 0, SP + 2);
    tick(); ex_valid = 1; ex_idx = 13; ex_hold = 1;
    tick(); ex_valid = 1; ex_idx = 13; rel_valid = 1; rel_mask = 16'h2000;
    watch(13, 0, SP + 2);

    tag = "R3/R4/R5/R6/R8/R9 random";
    for (int i = 0; i < 3000; i++) begin
      tick();
      chk_valid = $urandom_range(0, 3) != 0;
      for (int k = 0; k < OPS; k++)
        if ($urandom_range(0, 2) != 0) probe(k, $urandom_range(0, N - 1), $urandom_range(0, 1), $urandom_range(0, 1));
      if ($urandom_range(0, 3) == 0) begin
        iss_valid = 1; iss_idx = IW'($urandom_range(0, N - 1)); iss_wide = $urandom_range(0, 1);
      end
      if ($urandom_range(0, 3) == 0) begin
        ex_valid = 1; ex_idx = IW'($urandom_range(0, N - 1)); ex_wide = $urandom_range(0, 1);
        ex_hold = $urandom_range(0, 3) == 0;
      end
      if ($urandom_range(0, 7) == 0) begin
        rel_valid = 1; rel_mask = N'($urandom()); rel_delay = LW'($urandom_range(0, 5));
      end
    end
    tick();
    @(negedge clk); #2;
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule